// File: doc/BRIEF.md
# Address-Range Steering Classifier

This block decides, for one register address per cycle, how an access to a replicated register must be routed. It keeps a set of steering classes, each holding a short list of inclusive address windows and one programmed group/instance target. A separate list of no-steer windows marks addresses whose routing is fixed elsewhere. The classifier answers with a steer flag, the group and instance to steer to, and a miss flag for addresses no list knows about.

Classes are searched in a fixed priority order, with class 0 first. The first class owning a window that covers the address supplies the target. Only when every class misses is the no-steer list consulted. An address found nowhere falls back to target 0/0, with steering on and the miss flag raised. A configuration write port loads window bounds and class targets. Lookups go through a combinational search and then, by default, one output register stage.

Top module: `steer_classifier`

## Requirements
- R1: Classes are searched in ascending index order. The lowest-index class holding a live window that contains `lk_addr` drives `rs_group`/`rs_inst` from its target, with `rs_steer`=1 and `rs_miss`=0, even when a higher-index class or the no-steer list also covers the address.
- R2: A class with no live windows never matches, so the search continues with the next class.
- R3: The no-steer list (configuration class index N_TYPES, 8 by default) is used only when all classes miss. A hit there gives `rs_steer`=0, `rs_miss`=0 and group/instance 0.
- R4: An address matched by no class and no no-steer window gives `rs_steer`=1, group 0, instance 0 and `rs_miss`=1.
- R5: Windows are inclusive. Both the start and the end address match, and start-1 and end+1 do not.
- R6: A window slot is live only if it and every lower-index slot of the same list hold a nonzero end. A slot with end 0 ends the list, and the slots above it are ignored.
- R7: A write with `cfg_we`=1 and `cfg_op`=0 stores `cfg_start`/`cfg_end` into slot `cfg_idx` of list `cfg_type`. A write with `cfg_op`=1 stores `cfg_group`/`cfg_inst` as the target of class `cfg_type`. Later lookups use the new values.
- R8: Reset clears every slot's live state, so every lookup then misses. Writing end 0 to a slot removes it.
- R9: With REG_OUT=1, `rs_valid` equals `lk_valid` of the previous cycle, and the result fields belong to that lookup.
- R10: A lookup in the same cycle as a configuration write is resolved against the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 1 | 0 = window write, 1 = target write |
| cfg_type | input | TYPE_W (4) | Class index; N_TYPES selects the no-steer list |
| cfg_idx | input | IDX_W (4) | Window slot within the list |
| cfg_start | input | ADDR_W (24) | Window first address |
| cfg_end | input | ADDR_W (24) | Window last address; 0 ends the list |
| cfg_group | input | GRP_W (4) | Target group |
| cfg_inst | input | INST_W (4) | Target instance |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W (24) | Address to classify |
| rs_valid | output | 1 | Result valid |
| rs_steer | output | 1 | Steered access required |
| rs_group | output | GRP_W (4) | Steering group |
| rs_inst | output | INST_W (4) | Steering instance |
| rs_miss | output | 1 | Address found in no list |

## Verification
The collision that matters is a configuration write landing in the same cycle as a lookup that the write affects. The bench re-creates a removed window in the very cycle it looks up an address inside that window. It expects the pre-write answer (a miss) in that cycle and the class hit in the next cycle. Its behavioural model resolves each lookup before applying that cycle's write, so every such overlap in the sequence is judged the same way.

// File: rtl/steer_cls_pkg.sv
package steer_cls_pkg;
  typedef enum logic {
    CFG_RANGE  = 1'b0,
    CFG_TARGET = 1'b1
  } cfg_op_e;
endpackage

// File: rtl/steer_range_list.sv
// One list of inclusive address windows with end-of-list semantics.
module steer_range_list #(
  parameter int ADDR_W   = 24,
  parameter int N_RANGES = 16,
  localparam int IDX_W   = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic [ADDR_W-1:0] wr_end,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [N_RANGES-1:0] vld_q, vld_d;
  logic [ADDR_W-1:0]   lo_q [N_RANGES];
  logic [ADDR_W-1:0]   hi_q [N_RANGES];
  logic [N_RANGES-1:0] live, hit_vec;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = (wr_end != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lo_q[wr_idx] <= wr_start;
      hi_q[wr_idx] <= wr_end;
    end
  end

  for (genvar i = 0; i < N_RANGES; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign live[i] = vld_q[i];
    end else begin : g_rest
      assign live[i] = vld_q[i] & live[i-1];
      // R6: a slot only matches when the slot below it is populated
      p_list_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[i] |-> vld_q[i-1]);
    end
    assign hit_vec[i] = live[i] && (addr >= lo_q[i]) && (addr <= hi_q[i]);
  end

  assign hit = |hit_vec;

  // R8: a zero end removes the slot
  p_zero_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_end == '0) |=> !vld_q[$past(wr_idx)]);
endmodule

// File: rtl/steer_target_bank.sv
// Per-class group/instance targets.
module steer_target_bank #(
  parameter int N_TYPES = 8,
  parameter int GRP_W   = 4,
  parameter int INST_W  = 4,
  parameter int TYPE_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [TYPE_W-1:0]               wr_type,
  input  logic [GRP_W-1:0]                wr_group,
  input  logic [INST_W-1:0]               wr_inst,
  output logic [N_TYPES-1:0][GRP_W-1:0]   grp_o,
  output logic [N_TYPES-1:0][INST_W-1:0]  inst_o
);
  logic [N_TYPES-1:0][GRP_W-1:0]  grp_q, grp_d;
  logic [N_TYPES-1:0][INST_W-1:0] inst_q, inst_d;

  always_comb begin
    grp_d  = grp_q;
    inst_d = inst_q;
    for (int t = 0; t < N_TYPES; t++) begin
      if (wr_en && wr_type == TYPE_W'(t)) begin
        grp_d[t]  = wr_group;
        inst_d[t] = wr_inst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      inst_q <= '0;
    end else begin
      grp_q  <= grp_d;
      inst_q <= inst_d;
    end
  end

  assign grp_o  = grp_q;
  assign inst_o = inst_q;

  // R7: targets only change on a target write
  p_target_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(grp_q) && $stable(inst_q)));
endmodule

// File: rtl/steer_prio.sv
// Priority resolution across classes plus the no-steer and fallback cases.
module steer_prio #(
  parameter int N_TYPES = 8,
  parameter int GRP_W   = 4,
  parameter int INST_W  = 4
) (
  input  logic [N_TYPES-1:0]              hit,
  input  logic                            imp_hit,
  input  logic [N_TYPES-1:0][GRP_W-1:0]   grp_i,
  input  logic [N_TYPES-1:0][INST_W-1:0]  inst_i,
  output logic                            steer,
  output logic [GRP_W-1:0]                group,
  output logic [INST_W-1:0]               inst,
  output logic                            miss
);
  logic found;

  always_comb begin
    found = 1'b0;
    group = '0;
    inst  = '0;
    for (int t = N_TYPES - 1; t >= 0; t--) begin
      if (hit[t]) begin
        found = 1'b1;
        group = grp_i[t];
        inst  = inst_i[t];
      end
    end
    steer = found | ~imp_hit;
    miss  = ~found & ~imp_hit;
  end
endmodule

// File: rtl/steer_classifier.sv
module steer_classifier
  import steer_cls_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int N_TYPES  = 8,
  parameter int N_RANGES = 16,
  parameter int GRP_W    = 4,
  parameter int INST_W   = 4,
  parameter bit REG_OUT  = 1'b1,
  localparam int TYPE_W  = $clog2(N_TYPES + 1),
  localparam int IDX_W   = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_op,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic [GRP_W-1:0]  cfg_group,
  input  logic [INST_W-1:0] cfg_inst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rs_valid,
  output logic              rs_steer,
  output logic [GRP_W-1:0]  rs_group,
  output logic [INST_W-1:0] rs_inst,
  output logic              rs_miss
);
  logic                           range_wr, target_wr;
  logic [N_TYPES:0]               list_hit;
  logic [N_TYPES-1:0][GRP_W-1:0]  tgt_grp;
  logic [N_TYPES-1:0][INST_W-1:0] tgt_inst;
  logic                           c_steer, c_miss;
  logic [GRP_W-1:0]               c_group;
  logic [INST_W-1:0]              c_inst;

  assign range_wr  = cfg_we && (cfg_op == CFG_RANGE);
  assign target_wr = cfg_we && (cfg_op == CFG_TARGET);

  // lists 0..N_TYPES-1 are classes, list N_TYPES is the no-steer list
  for (genvar t = 0; t <= N_TYPES; t++) begin : g_list
    steer_range_list #(
      .ADDR_W   (ADDR_W),
      .N_RANGES (N_RANGES)
    ) i_list (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (range_wr && cfg_type == TYPE_W'(t)),
      .wr_idx   (cfg_idx),
      .wr_start (cfg_start),
      .wr_end   (cfg_end),
      .addr     (lk_addr),
      .hit      (list_hit[t])
    );
  end

  steer_target_bank #(
    .N_TYPES (N_TYPES),
    .GRP_W   (GRP_W),
    .INST_W  (INST_W),
    .TYPE_W  (TYPE_W)
  ) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (target_wr),
    .wr_type  (cfg_type),
    .wr_group (cfg_group),
    .wr_inst  (cfg_inst),
    .grp_o    (tgt_grp),
    .inst_o   (tgt_inst)
  );

  steer_prio #(
    .N_TYPES (N_TYPES),
    .GRP_W   (GRP_W),
    .INST_W  (INST_W)
  ) i_prio (
    .hit     (list_hit[N_TYPES-1:0]),
    .imp_hit (list_hit[N_TYPES]),
    .grp_i   (tgt_grp),
    .inst_i  (tgt_inst),
    .steer   (c_steer),
    .group   (c_group),
    .inst    (c_inst),
    .miss    (c_miss)
  );

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic              steer_q, miss_q;
    logic [GRP_W-1:0]  grp_q;
    logic [INST_W-1:0] inst_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= lk_valid;
    end

    always_ff @(posedge clk) begin
      if (lk_valid) begin
        steer_q <= c_steer;
        miss_q  <= c_miss;
        grp_q   <= c_group;
        inst_q  <= c_inst;
      end
    end

    assign rs_valid = vld_q;
    assign rs_steer = steer_q;
    assign rs_miss  = miss_q;
    assign rs_group = grp_q;
    assign rs_inst  = inst_q;

    // R9: one-cycle result latency
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid == $past(lk_valid));
  end else begin : g_comb
    assign rs_valid = lk_valid;
    assign rs_steer = c_steer;
    assign rs_miss  = c_miss;
    assign rs_group = c_group;
    assign rs_inst  = c_inst;
  end

  // R1: any class hit means a steered, non-miss answer
  p_class_hit_steers_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && |list_hit[N_TYPES-1:0]) |-> (c_steer && !c_miss));

  // R3: no-steer list hit with no class hit turns steering off
  p_nosteer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && list_hit[N_TYPES] && !(|list_hit[N_TYPES-1:0])) |-> !c_steer);

  // R4: a miss reports the default target
  p_miss_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_miss) |-> (rs_steer && rs_group == '0 && rs_inst == '0));

  // R3: an unsteered answer is never a miss and carries 0/0
  p_unsteered_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_steer) |-> (!rs_miss && rs_group == '0 && rs_inst == '0));
endmodule

// File: tb/test_steer_classifier.sv
`timescale 1ns/1ps
module test_steer_classifier;
  localparam int NT = 8;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_op;
  logic [3:0]  cfg_type, cfg_idx;
  logic [23:0] cfg_start, cfg_end;
  logic [3:0]  cfg_group, cfg_inst;
  logic        lk_valid;
  logic [23:0] lk_addr;
  logic        rs_valid, rs_steer, rs_miss;
  logic [3:0]  rs_group, rs_inst;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural model state
  logic [23:0] m_lo [0:NT][0:NR-1];
  logic [23:0] m_hi [0:NT][0:NR-1];
  bit          m_v  [0:NT][0:NR-1];
  logic [3:0]  m_g  [0:NT-1];
  logic [3:0]  m_i  [0:NT-1];

  always #4 clk = ~clk;

  steer_classifier i_steer_classifier (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_type(cfg_type), .cfg_idx(cfg_idx),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_group(cfg_group), .cfg_inst(cfg_inst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_steer(rs_steer), .rs_group(rs_group),
    .rs_inst(rs_inst), .rs_miss(rs_miss)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic model_lookup(input logic [23:0] a, output bit s, output logic [3:0] g,
                              output logic [3:0] ins, output bit m);
    bit done = 0;
    s = 1; g = 0; ins = 0; m = 1;
    for (int t = 0; t < NT && !done; t++) begin
      for (int k = 0; k < NR && m_v[t][k] && !done; k++) begin
        if (a >= m_lo[t][k] && a <= m_hi[t][k]) begin
          done = 1; s = 1; g = m_g[t]; ins = m_i[t]; m = 0;
        end
      end
    end
    if (!done) begin
      for (int k = 0; k < NR && m_v[NT][k] && !done; k++) begin
        if (a >= m_lo[NT][k] && a <= m_hi[NT][k]) begin
          done = 1; s = 0; g = 0; ins = 0; m = 0;
        end
      end
    end
  endtask

  // one clock: drive, predict from pre-write model, update model, compare
  task automatic step(input bit v, input logic [23:0] a,
                      input bit we, input bit op, input logic [3:0] ty, input logic [3:0] ix,
                      input logic [23:0] s, input logic [23:0] e,
                      input logic [3:0] g, input logic [3:0] ins, input string tag);
    bit exp_s, exp_m;
    logic [3:0] exp_g, exp_i;
    @(negedge clk);
    lk_valid = v; lk_addr = a;
    cfg_we = we; cfg_op = op; cfg_type = ty; cfg_idx = ix;
    cfg_start = s; cfg_end = e; cfg_group = g; cfg_inst = ins;
    model_lookup(a, exp_s, exp_g, exp_i, exp_m);
    if (we && !op) begin
      m_lo[ty][ix] = s; m_hi[ty][ix] = e; m_v[ty][ix] = (e != 0);
    end else if (we && op && ty < NT) begin
      m_g[ty] = g; m_i[ty] = ins;
    end
    @(posedge clk);
    #1;
    if (v) begin
      n_checks++;
      if (rs_valid !== 1'b1 || rs_steer !== exp_s || rs_group !== exp_g ||
          rs_inst !== exp_i || rs_miss !== exp_m) begin
        n_fail++;
        $display("FAIL %s addr=%h: actual v=%b s=%b g=%h i=%h m=%b expected v=1 s=%b g=%h i=%h m=%b",
                 tag, a, rs_valid, rs_steer, rs_group, rs_inst, rs_miss,
                 exp_s, exp_g, exp_i, exp_m);
      end
    end else begin
      n_checks++;
      if (rs_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL %s idle: actual rs_valid=%b expected 0", tag, rs_valid);
      end
    end
  endtask

  task automatic wr_range(input logic [3:0] ty, input logic [3:0] ix,
                          input logic [23:0] s, input logic [23:0] e, input string tag);
    step(0, 0, 1, 0, ty, ix, s, e, 0, 0, tag);
  endtask

  task automatic wr_tgt(input logic [3:0] ty, input logic [3:0] g, input logic [3:0] ins,
                        input string tag);
    step(0, 0, 1, 1, ty, 0, 0, 0, g, ins, tag);
  endtask

  task automatic look(input logic [23:0] a, input string tag);
    step(1, a, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int t = 0; t <= NT; t++)
      for (int k = 0; k < NR; k++) begin
        m_v[t][k] = 0; m_lo[t][k] = 0; m_hi[t][k] = 0;
      end
    for (int t = 0; t < NT; t++) begin
      m_g[t] = 0; m_i[t] = 0;
    end
    rst_n = 1'b0;
    lk_valid = 0; lk_addr = 0; cfg_we = 0; cfg_op = 0; cfg_type = 0; cfg_idx = 0;
    cfg_start = 0; cfg_end = 0; cfg_group = 0; cfg_inst = 0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (rs_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: actual rs_valid=%b expected 0", rs_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;

    look(24'h00B200, "R8 empty after reset");

    // class 0: bank window, class 1: four slice windows
    wr_range(0, 0, 24'h00B100, 24'h00B3FF, "R7");
    wr_tgt  (0, 4'h2, 4'h1, "R7");
    wr_range(1, 0, 24'h008150, 24'h00815F, "R7");
    wr_range(1, 1, 24'h009520, 24'h00955F, "R7");
    wr_range(1, 2, 24'h00DE80, 24'h00E8FF, "R7");
    wr_range(1, 3, 24'h024A00, 24'h024A7F, "R7");
    wr_tgt  (1, 4'h1, 4'h3, "R7");
    // class 2 overlaps class 0 at lower priority
    wr_range(2, 0, 24'h00B200, 24'h00B2FF, "R7");
    wr_tgt  (2, 4'h5, 4'h5, "R7");
    // class 3: hole at slot 0 hides slot 1
    wr_range(3, 1, 24'h003000, 24'h0030FF, "R7");
    wr_tgt  (3, 4'h7, 4'h7, "R7");
    // class 4: target only
    wr_tgt  (4, 4'hA, 4'hA, "R7");
    // no-steer list
    wr_range(4'd8, 0, 24'h001000, 24'h001FFF, "R7");
    wr_range(4'd8, 1, 24'h00B300, 24'h00B3FF, "R7");
    wr_tgt  (4'd8, 4'hF, 4'hF, "R7 target write to no-steer index");

    look(24'h00B100, "R5 window start");
    look(24'h00B3FF, "R5 window end");
    look(24'h00B0FF, "R5 below start");
    look(24'h00B400, "R5 above end");
    look(24'h00B200, "R1 overlap first class wins");
    look(24'h008150, "R1 slice window 0");
    look(24'h00955F, "R1 slice window 1");
    look(24'h00E000, "R1 slice window 2");
    look(24'h024A7F, "R1 slice window 3");
    look(24'h001800, "R3 no-steer hit");
    look(24'h00B380, "R3 class beats no-steer");
    look(24'h003050, "R6 slot behind hole ignored");
    look(24'h024A80, "R4 unknown address");
    look(24'h000000, "R4 address zero");

    // remove class 0 window: overlap now falls to class 2
    wr_range(0, 0, 24'h00B100, 24'h000000, "R8 end zero");
    look(24'h00B200, "R2 emptied class skipped");
    look(24'h00B380, "R3 no-steer after class removed");

    // same-cycle write and lookup
    step(1, 24'h00B150, 1, 0, 0, 0, 24'h00B100, 24'h00B3FF, 0, 0, "R10 lookup during write");
    look(24'h00B150, "R10 lookup after write");

    wr_tgt(1, 4'h9, 4'h2, "R7");
    look(24'h008155, "R7 retargeted class");

    step(0, 24'h008155, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle cycle");
    look(24'h009530, "R9 back-to-back 1");
    look(24'h001000, "R9 back-to-back 2");

    summary();
    $finish;
  end
endmodule